// File: doc/BRIEF.md
# Threshold Branch Resolver with Emulated Conditions

This block decides a relative conditional branch by comparing an accumulator value against an immediate threshold. The datapath has only two real comparators: "at least" (GE) and "below" (LT). The other three conditions are each carried out as a short sequence of those native compares. Greater-than and less-or-equal compare against threshold plus one. Equality runs a GE against threshold plus one. If that compare succeeds, the branch falls through. Otherwise a second GE against the threshold itself decides the branch.

Execution time therefore depends on the data. Each native compare occupies one slot of EXEC_CYC plus FETCH_CYC cycles. An equality test takes one slot when the accumulator is above the threshold and two slots otherwise.

A decoded request carries:
- a condition code,
- a threshold,
- a signed byte step.

The accumulator value and the current program counter are plain inputs. They are captured together with the request. The program counter counts 32-bit words, so the byte step is divided by four with sign preserved. The unit reports the next program counter, a taken flag and an error flag. A busy output and a one-cycle done strobe mark the end of each request.

Top module: `thr_branch_unit`

## Requirements
- R1: A request is accepted on a rising edge where req_valid is 1 and busy is 0. Condition, threshold, step, r0 and pc are captured on that edge. busy is 1 from the next cycle until the request completes. A request presented while busy is 1 is ignored. Input changes while busy do not alter the result.
- R2: Condition codes LT=1 and GE=4 are single native compares on unsigned values: taken when r0 < threshold (LT) or r0 >= threshold (GE). busy stays high for EXEC_CYC+FETCH_CYC cycles, 4 by default.
- R3: Condition code LE=2 is taken when r0 <= threshold, and GT=3 when r0 > threshold. Each costs one slot (4 cycles by default).
- R4: Condition code EQ=0 is taken exactly when r0 == threshold. It takes one slot when r0 > threshold and two slots (8 cycles by default) otherwise.
- R5: Threshold-plus-one never wraps. With threshold 0xFFFF:
  - GT is never taken.
  - LE is always taken.
  - EQ with r0 = 0xFFFF is taken after two slots.
- R6: When taken, next_pc equals the captured pc plus the byte step arithmetically shifted right by 2, modulo 2^PW. When not taken, next_pc equals pc + 1.
- R7: A step whose two low bits are not 00 is an error. err and done are 1 in the first busy cycle, taken is 0 and next_pc is pc + 1.
- R8: Condition codes 5, 6 and 7 are errors, handled exactly as in R7.
- R9: done is 1 for exactly one cycle per request, the last cycle in which busy is 1. taken and err are 0 whenever done is 0.
- R10: During and right after reset, busy, done, taken and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Branch request present |
| req_cond | input | 3 | Condition code (EQ=0, LT=1, LE=2, GT=3, GE=4) |
| req_thresh | input | DW | Immediate threshold |
| req_step | input | SW | Signed relative step in bytes |
| r0 | input | DW | Accumulator value compared with the threshold |
| pc | input | PW | Current program counter in words |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid this cycle |
| taken | output | 1 | Branch taken (valid with done) |
| err | output | 1 | Request rejected (valid with done) |
| next_pc | output | PW | Following program counter (valid with done) |

## Verification
The bench uses the default parameters:
- A 16-bit data width, so the all-ones threshold 0xFFFF is a directed corner, and the plus-one rewrite is exercised right where it could wrap.
- A 10-bit step, so negative steps that carry the program counter below zero are reachable from small pc values.
- Two execute cycles and two fetch cycles, so the 4-cycle and 8-cycle equality paths are told apart by counting busy cycles.

The random phase places r0 within two of the threshold, which keeps most draws on the equality boundary for every condition.

// File: rtl/thr_branch_pkg.sv
package thr_branch_pkg;

   typedef enum logic [2:0] {
      COND_EQ = 3'd0,
      COND_LT = 3'd1,
      COND_LE = 3'd2,
      COND_GT = 3'd3,
      COND_GE = 3'd4
   } cond_e;

   // one native compare step
   typedef struct packed {
      logic op_lt;       // 1: below, 0: at-least
      logic add_one;     // compare against threshold + 1
      logic early_exit;  // hit ends the request as not taken, miss moves to next slot
   } uop_t;

   function automatic logic cond_legal(input logic [2:0] c);
      return (c <= 3'd4);
   endfunction

   function automatic uop_t decode_uop(input logic [2:0] c, input logic slot);
      uop_t u;
      u = '{op_lt: 1'b0, add_one: 1'b0, early_exit: 1'b0};
      case (c)
         COND_LT: u.op_lt = 1'b1;
         COND_LE: begin
            u.op_lt   = 1'b1;
            u.add_one = 1'b1;
         end
         COND_GT: u.add_one = 1'b1;
         COND_EQ: begin
            if (!slot) begin
               u.add_one    = 1'b1;
               u.early_exit = 1'b1;
            end
         end
         default: ;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/thr_branch_cmp.sv
module thr_branch_cmp #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] thr,
   input  logic          add_one,
   input  logic          op_lt,
   output logic          hit
);

   // one extra bit keeps threshold + 1 from wrapping
   logic [DW:0] a_w;
   logic [DW:0] t_w;
   logic        ge;

   always_comb begin
      a_w = {1'b0, a};
      t_w = {1'b0, thr} + {{DW{1'b0}}, add_one};
      ge  = (a_w >= t_w);
      hit = op_lt ? ~ge : ge;
   end

endmodule

// File: rtl/thr_branch_target.sv
module thr_branch_target #(
   parameter int SW = 10,
   parameter int PW = 16
) (
   input  logic [PW-1:0] pc,
   input  logic [SW-3:0] step_words,
   output logic [PW-1:0] target,
   output logic [PW-1:0] fallthru
);

   localparam int WS = SW - 2;

   logic [PW-1:0] offset;

   generate
      if (WS >= PW) begin : g_trunc
         assign offset = step_words[PW-1:0];
      end else begin : g_sext
         assign offset = {{(PW-WS){step_words[WS-1]}}, step_words};
      end
   endgenerate

   assign target   = pc + offset;
   assign fallthru = pc + PW'(1);

endmodule

// File: rtl/thr_branch_unit.sv
module thr_branch_unit
   import thr_branch_pkg::*;
#(
   parameter int DW        = 16,
   parameter int SW        = 10,
   parameter int PW        = 16,
   parameter int EXEC_CYC  = 2,
   parameter int FETCH_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_cond,
   input  logic [DW-1:0] req_thresh,
   input  logic [SW-1:0] req_step,
   input  logic [DW-1:0] r0,
   input  logic [PW-1:0] pc,
   output logic          busy,
   output logic          done,
   output logic          taken,
   output logic          err,
   output logic [PW-1:0] next_pc
);

   localparam int SLOT = EXEC_CYC + FETCH_CYC;
   localparam int CW   = $clog2(SLOT);
   localparam int LW   = CW + 2;

   generate
      if (DW < 2)        begin : g_bad_dw   $error("DW must be at least 2");        end
      if (SW < 3)        begin : g_bad_sw   $error("SW must be at least 3");        end
      if (PW < 2)        begin : g_bad_pw   $error("PW must be at least 2");        end
      if (EXEC_CYC < 1)  begin : g_bad_exec $error("EXEC_CYC must be positive");    end
      if (FETCH_CYC < 1) begin : g_bad_fet  $error("FETCH_CYC must be positive");   end
   endgenerate

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic          slot_q;
   logic          err_q;
   logic [2:0]    cond_q;
   logic [DW-1:0] thr_q;
   logic [DW-1:0] r0_q;
   logic [PW-1:0] pc_q;
   logic [SW-1:0] step_q;

   logic          accept;
   logic          bad_req;
   uop_t          uop;
   logic          hit;
   logic          slot_end;
   logic          go_next;
   logic          fin_taken;
   logic [PW-1:0] target_w;
   logic [PW-1:0] fall_w;

   assign accept  = req_valid && !run_q;
   assign bad_req = !cond_legal(req_cond) || (req_step[1:0] != 2'b00);
   assign uop     = decode_uop(cond_q, slot_q);

   thr_branch_cmp #(.DW(DW)) u_cmp (
      .a       (r0_q),
      .thr     (thr_q),
      .add_one (uop.add_one),
      .op_lt   (uop.op_lt),
      .hit     (hit)
   );

   thr_branch_target #(.SW(SW), .PW(PW)) u_tgt (
      .pc         (pc_q),
      .step_words (step_q[SW-1:2]),
      .target     (target_w),
      .fallthru   (fall_w)
   );

   assign slot_end  = run_q && (cnt_q == '0);
   assign go_next   = slot_end && !err_q && uop.early_exit && !hit;
   assign fin_taken = !err_q && !uop.early_exit && hit;

   assign busy    = run_q;
   assign done    = slot_end && !go_next;
   assign taken   = done && fin_taken;
   assign err     = done && err_q;
   assign next_pc = fin_taken ? target_w : fall_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         slot_q <= 1'b0;
         err_q  <= 1'b0;
         cond_q <= '0;
         thr_q  <= '0;
         r0_q   <= '0;
         pc_q   <= '0;
         step_q <= '0;
      end else if (accept) begin
         run_q  <= 1'b1;
         slot_q <= 1'b0;
         err_q  <= bad_req;
         cnt_q  <= bad_req ? '0 : CW'(SLOT - 1);
         cond_q <= req_cond;
         thr_q  <= req_thresh;
         r0_q   <= r0;
         pc_q   <= pc;
         step_q <= req_step;
      end else if (run_q) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
         end else if (go_next) begin
            slot_q <= 1'b1;
            cnt_q  <= CW'(SLOT - 1);
         end else begin
            run_q <= 1'b0;
         end
      end
   end

   // busy-cycle counter used only by the latency checks
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (accept) lat_q <= LW'(1);
      else if (run_q && !done) lat_q <= lat_q + LW'(1);
   end

   assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   assert_hold_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(pc_q) && $stable(r0_q)));

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(req_valid)) |=> !busy);

   assert_err_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!taken && lat_q == LW'(1)));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (lat_q == LW'(SLOT) || lat_q == LW'(2*SLOT)));

   assert_eq_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && cond_q == COND_EQ && lat_q == LW'(SLOT)) |-> !taken);

   assert_gt_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && cond_q == COND_GT && (&thr_q)) |-> !taken);

   assert_le_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && cond_q == COND_LE && (&thr_q)) |-> taken);

endmodule

// File: tb/thr_branch_unit_bench.sv
module thr_branch_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 16;
   localparam int SW   = 10;
   localparam int PW   = 16;
   localparam int EXC  = 2;
   localparam int FET  = 2;
   localparam int SLOT = EXC + FET;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_cond = '0;
   logic [DW-1:0] req_thresh = '0;
   logic [SW-1:0] req_step = '0;
   logic [DW-1:0] r0 = '0;
   logic [PW-1:0] pc = '0;
   logic          busy, done, taken, err;
   logic [PW-1:0] next_pc;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_branch_unit #(.DW(DW), .SW(SW), .PW(PW), .EXEC_CYC(EXC), .FETCH_CYC(FET)) u_thr_branch_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cond(req_cond),
      .req_thresh(req_thresh), .req_step(req_step), .r0(r0), .pc(pc),
      .busy(busy), .done(done), .taken(taken), .err(err), .next_pc(next_pc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_err(input logic [2:0] c, input logic [SW-1:0] st);
      return (c > 3'd4) || (st[1:0] != 2'b00);
   endfunction

   function automatic bit exp_taken(input logic [2:0] c, input logic [DW-1:0] th, input logic [DW-1:0] a);
      case (c)
         3'd0: return a == th;
         3'd1: return a <  th;
         3'd2: return a <= th;
         3'd3: return a >  th;
         3'd4: return a >= th;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int exp_lat(input logic [2:0] c, input logic [DW-1:0] th,
                                  input logic [DW-1:0] a, input bit e);
      if (e) return 1;
      if (c == 3'd0) return (a > th) ? SLOT : 2*SLOT;
      return SLOT;
   endfunction

   function automatic logic [PW-1:0] exp_pc(input bit tk, input logic [SW-1:0] st, input logic [PW-1:0] p);
      logic signed [SW-1:0] s;
      logic signed [SW-1:0] w;
      s = st;
      w = s >>> 2;
      return tk ? (p + PW'(w)) : (p + PW'(1));
   endfunction

   function automatic string tag_of(input logic [2:0] c, input bit e, input logic [SW-1:0] st);
      if (c > 3'd4)          return "R8";
      if (e && st[1:0] != 0) return "R7";
      if (c == 3'd0)         return "R4";
      if (c == 3'd2 || c == 3'd3) return "R3";
      return "R2";
   endfunction

   task automatic do_br(input logic [2:0] c, input logic [DW-1:0] th, input logic [SW-1:0] st,
                        input logic [DW-1:0] a, input logic [PW-1:0] p, input bit junk_in);
      bit e;
      bit tk;
      bit fin;
      bit junk;
      int lat;
      string tg;
      e    = exp_err(c, st);
      tk   = e ? 1'b0 : exp_taken(c, th, a);
      tg   = tag_of(c, e, st);
      junk = junk_in && !e;
      fin  = 1'b0;
      lat  = 0;
      @(negedge clk);
      req_valid = 1'b1; req_cond = c; req_thresh = th; req_step = st; r0 = a; pc = p;
      for (int k = 0; k < 40 && !fin; k++) begin
         @(negedge clk);
         if (busy) lat++;
         if (done) begin
            fin = 1'b1;
            chk({tg, " latency"}, 32'(lat), 32'(exp_lat(c, th, a, e)));
            chk({tg, " taken"}, 32'(taken), 32'(tk));
            chk((c > 3'd4) ? "R8 err" : "R7 err", 32'(err), 32'(e));
            chk("R6 next_pc", 32'(next_pc), 32'(exp_pc(tk, st, p)));
         end else begin
            chk("R9 quiet outputs", {30'd0, taken, err}, 32'd0);
         end
         if (k == 0) begin
            req_valid = junk && !fin;
            req_cond = 3'($urandom); req_thresh = DW'($urandom);
            req_step = SW'($urandom); r0 = DW'($urandom); pc = PW'($urandom);
         end else begin
            req_valid = 1'b0;
         end
      end
      req_valid = 1'b0;
      if (!fin) chk("R9 done missing", 32'd0, 32'd1);
      @(negedge clk);
      chk("R9 single done", {30'd0, done, busy}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {28'd0, busy, done, taken, err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after reset", {28'd0, busy, done, taken, err}, 32'd0);

      // boundary sweep for every legal condition
      for (int c = 0; c < 5; c++) begin
         for (int d = -1; d <= 1; d++) begin
            do_br(3'(c), 16'h1000, 10'h010, 16'(32'h1000 + d), 16'h0200, 1'b0);
         end
      end
      // all-ones threshold, no wrap of threshold + 1 (R5)
      do_br(3'd3, 16'hFFFF, 10'h008, 16'hFFFF, 16'h0040, 1'b0);
      do_br(3'd2, 16'hFFFF, 10'h008, 16'hFFFF, 16'h0040, 1'b0);
      do_br(3'd2, 16'hFFFF, 10'h008, 16'h0000, 16'h0040, 1'b0);
      do_br(3'd0, 16'hFFFF, 10'h008, 16'hFFFF, 16'h0040, 1'b0);
      do_br(3'd0, 16'hFFFF, 10'h008, 16'hFFFE, 16'h0040, 1'b0);
      // zero threshold
      do_br(3'd1, 16'h0000, 10'h004, 16'h0000, 16'h0010, 1'b0);
      do_br(3'd4, 16'h0000, 10'h004, 16'h0000, 16'h0010, 1'b0);
      // negative step below zero (R6)
      do_br(3'd4, 16'h0005, 10'h3F0, 16'h0009, 16'h0002, 1'b0);
      do_br(3'd4, 16'h0005, 10'h200, 16'h0009, 16'h0100, 1'b0);
      // misaligned step (R7) and illegal codes (R8)
      do_br(3'd4, 16'h0001, 10'h006, 16'h0009, 16'h0100, 1'b0);
      do_br(3'd0, 16'h0009, 10'h001, 16'h0009, 16'h0100, 1'b0);
      do_br(3'd5, 16'h0001, 10'h004, 16'h0009, 16'h0100, 1'b0);
      do_br(3'd7, 16'h0001, 10'h004, 16'h0009, 16'h0100, 1'b0);
      // requests and input changes while busy are ignored (R1)
      do_br(3'd0, 16'h0033, 10'h00C, 16'h0033, 16'h0300, 1'b1);
      do_br(3'd1, 16'h0033, 10'h3FC, 16'h0030, 16'h0300, 1'b1);

      for (int i = 0; i < 300; i++) begin
         logic [DW-1:0] a;
         logic [DW-1:0] th;
         logic [2:0]    c;
         logic [SW-1:0] st;
         a  = DW'($urandom);
         th = a + DW'(($urandom % 5) - 2);
         c  = ($urandom % 10 == 0) ? 3'd5 + 3'($urandom % 3) : 3'($urandom % 5);
         st = SW'($urandom);
         if ($urandom % 8 != 0) st[1:0] = 2'b00;
         do_br(c, th, st, a, PW'($urandom), ($urandom % 4) == 0);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule